// File: doc/BRIEF.md
# Overhead and Z-Bit Side-Port Sequencer

This block sits beside a DSL framer and decides, for every bit time the framer announces, whether that bit belongs to a narrow serial side port. The framer gives a one-cycle `tick` per bit time, a `sof` marker on the first tick of each frame, and a slot kind that says whether the current bit is an overhead (OH) bit, a Z bit, or something else (sync, payload, stuff). The block counts OH and Z ordinals from the start of the frame. It raises a port enable with a type tag for each slot that is a member of the port, and gaps the slots that are not. It forwards the received line bit onto the port. It also returns to the framer the transmit bit for every slot the block is responsible for.

Whether an OH bit is a member of the port depends on a per-ordinal "predefined" mask. Predefined OH bits are inserted by the framer itself. Z bits are routed either to the port or to a register bank, selected by one control bit. In hardware-control mode, every Z bit and every user OH bit uses the port, and a fixed mask parameter replaces the configured one. In fractional-T1 mode, the Z positions carry payload and are handled by neither path. The register bank holds a transmit Z word that is loaded once per frame at `sof`. It publishes the received Z word when the last Z slot of the frame arrives.

Top module: `ohz_port_seq`

## Requirements
- R1: While `rst_n` is low, `sp_en`, `sp_tag`, `sp_rx_dout`, `frm_tx_valid`, `frm_tx_bit` and `z_rx_word` are all zero, and a reset in the middle of operation clears `z_rx_word`.
- R2: A cycle without `tick` does nothing and does not advance the ordinals. A tick whose `slot_kind` is 0 (sync/payload/stuff) or 3 (reserved) does not raise `sp_en` or `frm_tx_valid`.
- R3: An OH tick (`slot_kind`=1) whose ordinal is not predefined raises `sp_en` with `sp_tag`=0 one cycle later, and `sp_rx_dout` equals the `frm_rx_bit` seen with the tick. One cycle after that, `frm_tx_valid` is 1 and `frm_tx_bit` equals `sp_tx_din` as sampled during the enable cycle.
- R4: OH ordinal i (0 = first OH slot after `sof`) is predefined when bit i of `cfg_oh_predef` is 1. Its slot is a gap: `sp_en` and `frm_tx_valid` both stay 0.
- R5: With `cfg_z_port`=1, each Z tick (`slot_kind`=2) raises `sp_en` with `sp_tag`=1, and it is otherwise timed like R3.
- R6: With `cfg_z_port`=0, a Z tick keeps `sp_en` at 0. Two cycles later, `frm_tx_valid` is 1 and `frm_tx_bit` is bit j of the held transmit word, where j is the Z ordinal counted from 0 after `sof`.
- R7: The held transmit Z word is `z_tx_word` as sampled on the `sof` tick. Later changes to `z_tx_word` have no effect within that frame.
- R8: In register mode, `z_rx_word` changes only in the cycle after the Z tick with ordinal 47, and then bit j holds the `frm_rx_bit` from Z ordinal j of that frame.
- R9: With `cfg_hw_ctl`=1, Z bits use the port whatever the value of `cfg_z_port`, and the parameter `HW_PREDEF` replaces `cfg_oh_predef` as the OH mask.
- R10: With `cfg_frac_t1`=1, Z ticks raise neither `sp_en` nor `frm_tx_valid`, and `z_rx_word` keeps its value. This mode overrides R5, R6 and R9 for Z bits.
- R11: A `sof` tick restarts both ordinals at 0, even when the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One bit time of the line frame |
| sof | input | 1 | First tick of a frame (slot kind 0) |
| slot_kind | input | 2 | 0 other, 1 OH, 2 Z, 3 reserved |
| cfg_z_port | input | 1 | 1: Z bits on the port, 0: Z bits in the register bank |
| cfg_hw_ctl | input | 1 | Hardware-control mode |
| cfg_frac_t1 | input | 1 | Fractional-T1 mode; Z positions are payload |
| cfg_oh_predef | input | 42 | Per-OH-ordinal predefined mask |
| frm_rx_bit | input | 1 | Received line bit for the ticked slot |
| sp_tx_din | input | 1 | Port transmit bit, valid in the `sp_en` cycle |
| z_tx_word | input | 48 | Transmit Z word from the register bank |
| sp_en | output | 1 | Port slot enable |
| sp_tag | output | 1 | Port bit type: 0 OH, 1 Z |
| sp_rx_dout | output | 1 | Received bit presented on the port |
| frm_tx_valid | output | 1 | Block supplies the transmit bit of this slot |
| frm_tx_bit | output | 1 | Transmit bit towards the framer |
| z_rx_word | output | 48 | Received Z word, published once per frame |

## Verification
The assertions rely on the framer's contract. `sof` comes only with a tick of slot kind 0. No frame announces more than 42 OH or 48 Z slots before the next `sof`. The mode inputs change only while no slot is in flight. The stimulus builds every frame from a sync run, then four OH groups of 2, 10, 10 and 10 slots. Each group is followed by twelve blocks of one Z slot and two payload slots, and the frame ends with a stuff slot. Ticks are spaced three cycles apart, and configuration is changed only between frames. One directed case aborts a frame early with a new `sof`, which stays inside the ordinal limits.

// File: rtl/ohz_pkg.sv
package ohz_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_OH   = 2'd1,
        SLOT_Z    = 2'd2,
        SLOT_RSVD = 2'd3
    } slot_e;

    // Per-tick routing decision
    typedef struct packed {
        logic hit_z;   // tick lands on a Z slot
        logic port;    // slot is a member of the side port
        logic reg_z;   // Z slot served by the register bank
        logic drive;   // block supplies the transmit bit
    } route_t;

    // First pipeline stage: port-facing
    typedef struct packed {
        logic en;
        logic tag;
        logic rx;
        logic drive;
        logic reg_bit;
    } stg1_t;

    // Second pipeline stage: framer-facing
    typedef struct packed {
        logic valid;
        logic dat;
    } stg2_t;

endpackage

// File: rtl/ohz_slot_ctr.sv
module ohz_slot_ctr
    import ohz_pkg::*;
#(
    parameter int N_OH = 42,
    parameter int N_Z  = 48,
    localparam int OW  = $clog2(N_OH + 1),
    localparam int ZW  = $clog2(N_Z + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sof,
    input  slot_e         kind,
    output logic [OW-1:0] oh_idx,
    output logic [ZW-1:0] z_idx,
    output logic          z_last
);

    localparam logic [OW-1:0] OH_END = OW'(N_OH);
    localparam logic [ZW-1:0] Z_END  = ZW'(N_Z);
    localparam logic [ZW-1:0] Z_LAST = ZW'(N_Z - 1);

    typedef struct packed {
        logic [OW-1:0] oh;
        logic [ZW-1:0] z;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (tick) begin
            if (sof) begin
                ctr_d.oh = '0;
                ctr_d.z  = '0;
            end else if (kind == SLOT_OH && ctr_q.oh != OH_END) begin
                ctr_d.oh = ctr_q.oh + 1'b1;
            end else if (kind == SLOT_Z && ctr_q.z != Z_END) begin
                ctr_d.z = ctr_q.z + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign oh_idx = ctr_q.oh;
    assign z_idx  = ctr_q.z;
    assign z_last = (ctr_q.z == Z_LAST);

    AST_SOF_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (tick && kind == SLOT_IDLE)); // R11
    AST_OH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sof && kind == SLOT_OH) |-> (ctr_q.oh != OH_END)); // R4
    AST_Z_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sof && kind == SLOT_Z) |-> (ctr_q.z != Z_END)); // R8

endmodule

// File: rtl/ohz_route.sv
module ohz_route
    import ohz_pkg::*;
#(
    parameter int              N_OH      = 42,
    parameter logic [N_OH-1:0] HW_PREDEF = '0,
    localparam int             OW        = $clog2(N_OH + 1)
) (
    input  logic            tick,
    input  logic            sof,
    input  slot_e           kind,
    input  logic [OW-1:0]   oh_idx,
    input  logic            cfg_z_port,
    input  logic            cfg_hw_ctl,
    input  logic            cfg_frac_t1,
    input  logic [N_OH-1:0] cfg_oh_predef,
    output route_t          rt
);

    localparam logic [OW-1:0] OH_LAST = OW'(N_OH - 1);

    logic hit_oh, hit_z, predef, oh_user, z_live, z_on_port;

    always_comb begin
        hit_oh = tick && !sof && (kind == SLOT_OH);
        hit_z  = tick && !sof && (kind == SLOT_Z);

        // Out-of-range ordinals count as predefined (never on the port)
        predef = 1'b1;
        if (oh_idx <= OH_LAST) begin
            predef = cfg_hw_ctl ? HW_PREDEF[oh_idx] : cfg_oh_predef[oh_idx];
        end

        oh_user   = hit_oh && !predef;
        z_live    = hit_z && !cfg_frac_t1;
        z_on_port = cfg_hw_ctl || cfg_z_port;

        rt.hit_z = hit_z;
        rt.port  = oh_user || (z_live && z_on_port);
        rt.reg_z = z_live && !z_on_port;
        rt.drive = oh_user || z_live;
    end

endmodule

// File: rtl/ohz_zbank.sv
module ohz_zbank #(
    parameter int  N_Z = 48,
    localparam int ZW  = $clog2(N_Z + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N_Z-1:0] z_tx_word,
    input  logic [ZW-1:0]  z_idx,
    input  logic           wr,
    input  logic           rx_bit,
    input  logic           last,
    output logic           tx_bit,
    output logic [N_Z-1:0] z_rx_word
);

    localparam logic [ZW-1:0] Z_LAST = ZW'(N_Z - 1);

    typedef struct packed {
        logic [N_Z-1:0] hold;   // transmit word for the current frame
        logic [N_Z-1:0] shadow; // receive word being assembled
        logic [N_Z-1:0] pub;    // receive word of the last full frame
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d.hold = z_tx_word;
        end
        if (wr && z_idx <= Z_LAST) begin
            bank_d.shadow[z_idx] = rx_bit;
            if (last) begin
                bank_d.pub = bank_d.shadow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign tx_bit    = (z_idx <= Z_LAST) ? bank_q.hold[z_idx] : 1'b0;
    assign z_rx_word = bank_q.pub;

    AST_HOLD_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_q.hold) |-> $past(load)); // R7

endmodule

// File: rtl/ohz_port_seq.sv
module ohz_port_seq
    import ohz_pkg::*;
#(
    parameter int              N_OH      = 42,
    parameter int              N_Z       = 48,
    parameter logic [N_OH-1:0] HW_PREDEF = 42'h200_0000_0003
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            sof,
    input  logic [1:0]      slot_kind,
    input  logic            cfg_z_port,
    input  logic            cfg_hw_ctl,
    input  logic            cfg_frac_t1,
    input  logic [N_OH-1:0] cfg_oh_predef,
    input  logic            frm_rx_bit,
    input  logic            sp_tx_din,
    input  logic [N_Z-1:0]  z_tx_word,
    output logic            sp_en,
    output logic            sp_tag,
    output logic            sp_rx_dout,
    output logic            frm_tx_valid,
    output logic            frm_tx_bit,
    output logic [N_Z-1:0]  z_rx_word
);

    localparam int OW = $clog2(N_OH + 1);
    localparam int ZW = $clog2(N_Z + 1);

    slot_e         kind;
    logic [OW-1:0] oh_idx;
    logic [ZW-1:0] z_idx;
    logic          z_last;
    logic          reg_tx_bit;
    route_t        rt;

    assign kind = slot_e'(slot_kind);

    ohz_slot_ctr #(.N_OH(N_OH), .N_Z(N_Z)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sof    (sof),
        .kind   (kind),
        .oh_idx (oh_idx),
        .z_idx  (z_idx),
        .z_last (z_last)
    );

    ohz_route #(.N_OH(N_OH), .HW_PREDEF(HW_PREDEF)) u_route (
        .tick          (tick),
        .sof           (sof),
        .kind          (kind),
        .oh_idx        (oh_idx),
        .cfg_z_port    (cfg_z_port),
        .cfg_hw_ctl    (cfg_hw_ctl),
        .cfg_frac_t1   (cfg_frac_t1),
        .cfg_oh_predef (cfg_oh_predef),
        .rt            (rt)
    );

    ohz_zbank #(.N_Z(N_Z)) u_zbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tick && sof),
        .z_tx_word (z_tx_word),
        .z_idx     (z_idx),
        .wr        (rt.reg_z),
        .rx_bit    (frm_rx_bit),
        .last      (z_last),
        .tx_bit    (reg_tx_bit),
        .z_rx_word (z_rx_word)
    );

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    always_comb begin
        s1_d.en      = rt.port;
        s1_d.tag     = rt.port && rt.hit_z;
        s1_d.rx      = rt.port && frm_rx_bit;
        s1_d.drive   = rt.drive;
        s1_d.reg_bit = rt.reg_z && reg_tx_bit;

        // Port peer supplies its bit during the enable cycle
        s2_d.valid = s1_q.drive;
        s2_d.dat   = s1_q.drive && (s1_q.en ? sp_tx_din : s1_q.reg_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sp_en        = s1_q.en;
    assign sp_tag       = s1_q.tag;
    assign sp_rx_dout   = s1_q.rx;
    assign frm_tx_valid = s2_q.valid;
    assign frm_tx_bit   = s2_q.dat;

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sp_en |-> $past(tick)); // R2
    AST_TAG_WITHIN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sp_tag |-> sp_en); // R5
    AST_RX_QUIET_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_en |-> !sp_rx_dout); // R4
    AST_PORT_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_tx_valid && $past(sp_en)) |-> (frm_tx_bit == $past(sp_tx_din))); // R3
    AST_FRAC_NO_Z_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        sp_tag |-> !$past(cfg_frac_t1)); // R10
    AST_ZRX_AT_LAST_Z: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(z_rx_word) |-> $past(tick && slot_kind == 2'd2)); // R8

endmodule

// File: tb/ohz_port_seq_test.sv
module ohz_port_seq_test;

    localparam int          NOH = 42;
    localparam int          NZ  = 48;
    localparam logic [41:0] HWM = 42'h200_0000_0003;

    typedef struct packed {
        logic        hw;
        logic        frac;
        logic        zport;
        logic [41:0] mask;
        logic [47:0] ztx;
        logic [7:0]  seed;
    } vec_t;

    // Frame scenarios: hw, frac, zport, OH mask, tx Z word, bit seed
    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 1'b1, 42'h000_0000_0F00, 48'hA5A5_0F0F_3C3C, 8'd3},
        '{1'b0, 1'b0, 1'b0, 42'h003_0000_0001, 48'h1234_5678_9ABC, 8'd5},
        '{1'b1, 1'b0, 1'b0, 42'h3FF_FFFF_FFFF, 48'hFFFF_0000_FFFF, 8'd7},
        '{1'b0, 1'b1, 1'b1, 42'h000_0000_0000, 48'hDEAD_BEEF_CAFE, 8'd9},
        '{1'b0, 1'b0, 1'b0, 42'h155_5555_5555, 48'h0F0F_F0F0_AAAA, 8'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sof = 1'b0;
    logic [1:0]  slot_kind = 2'd0;
    logic        cfg_z_port = 1'b0;
    logic        cfg_hw_ctl = 1'b0;
    logic        cfg_frac_t1 = 1'b0;
    logic [41:0] cfg_oh_predef = '0;
    logic        frm_rx_bit = 1'b0;
    logic        sp_tx_din = 1'b0;
    logic [47:0] z_tx_word = '0;
    logic        sp_en, sp_tag, sp_rx_dout, frm_tx_valid, frm_tx_bit;
    logic [47:0] z_rx_word;

    always #4 clk = ~clk;

    ohz_port_seq #(.N_OH(NOH), .N_Z(NZ), .HW_PREDEF(HWM)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sof(sof), .slot_kind(slot_kind),
        .cfg_z_port(cfg_z_port), .cfg_hw_ctl(cfg_hw_ctl), .cfg_frac_t1(cfg_frac_t1),
        .cfg_oh_predef(cfg_oh_predef), .frm_rx_bit(frm_rx_bit), .sp_tx_din(sp_tx_din),
        .z_tx_word(z_tx_word), .sp_en(sp_en), .sp_tag(sp_tag), .sp_rx_dout(sp_rx_dout),
        .frm_tx_valid(frm_tx_valid), .frm_tx_bit(frm_tx_bit), .z_rx_word(z_rx_word)
    );

    int          errs = 0;
    int          checks = 0;
    int          oh_n = 0;
    int          z_n = 0;
    int          k = 0;
    logic [7:0]  seed = 8'd1;
    logic [47:0] held_tx = '0;
    logic [47:0] shadow = '0;
    logic [47:0] exp_zrx = '0;
    bit          r11_mode = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic do_sof();
        @(negedge clk);
        tick = 1'b1; sof = 1'b1; slot_kind = 2'd0;
        held_tx = z_tx_word;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; sof = 1'b0;
        oh_n = 0; z_n = 0;
    endtask

    // One ticked slot, three cycles long, with expectations from the requirements
    task automatic do_slot(input logic [1:0] kind);
        logic  rxb, txb, predef, port, regz, drive, is_oh, is_z;
        int    oi, zi;
        string tag;
        rxb = ^(8'(k * seed));
        txb = ^(8'(k * seed + 1));
        k++;
        is_oh = (kind == 2'd1);
        is_z  = (kind == 2'd2);
        oi = oh_n; zi = z_n;
        port = 1'b0; regz = 1'b0; drive = 1'b0; tag = "R2";
        if (is_oh) begin
            predef = cfg_hw_ctl ? HWM[oi] : cfg_oh_predef[oi];
            port  = !predef;
            drive = !predef;
            tag = cfg_hw_ctl ? "R9" : (predef ? "R4" : "R3");
            if (r11_mode) tag = "R11";
        end else if (is_z) begin
            if (cfg_frac_t1) begin
                tag = "R10";
            end else begin
                port  = cfg_hw_ctl || cfg_z_port;
                regz  = !port;
                drive = 1'b1;
                tag = cfg_hw_ctl ? "R9" : (cfg_z_port ? "R5" : "R6");
            end
        end

        @(negedge clk);
        tick = 1'b1; slot_kind = kind; frm_rx_bit = rxb;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; slot_kind = 2'd0; frm_rx_bit = 1'b0;
        chk(tag, 64'(sp_en), 64'(port));
        chk(tag, 64'(sp_tag), 64'(port && is_z));
        chk(tag, 64'(sp_rx_dout), 64'(port && rxb));
        if (regz) begin
            shadow[zi] = rxb;
            if (zi == NZ - 1) exp_zrx = shadow;
        end
        if (is_z) chk(cfg_frac_t1 ? "R10" : "R8", 64'(z_rx_word), 64'(exp_zrx));
        if (is_oh) oh_n++;
        if (is_z) z_n++;
        sp_tx_din = txb;
        @(posedge clk);
        @(negedge clk);
        sp_tx_din = 1'b0;
        chk(tag, 64'(frm_tx_valid), 64'(drive));
        if (drive) chk(regz ? "R7" : tag, 64'(frm_tx_bit), 64'(regz ? held_tx[zi] : txb));
        chk(tag, 64'(sp_en), 64'd0);
        @(posedge clk);
    endtask

    task automatic run_frame(input int v);
        @(negedge clk);
        cfg_hw_ctl    = VECS[v].hw;
        cfg_frac_t1   = VECS[v].frac;
        cfg_z_port    = VECS[v].zport;
        cfg_oh_predef = VECS[v].mask;
        seed          = VECS[v].seed;
        z_tx_word     = VECS[v].ztx;
        do_sof();
        z_tx_word = ~VECS[v].ztx;   // R7: must not reach this frame
        repeat (3) do_slot(2'd0);
        for (int g = 0; g < 4; g++) begin
            repeat ((g == 0) ? 2 : 10) do_slot(2'd1);
            for (int b = 0; b < 12; b++) begin
                do_slot(2'd2);
                do_slot(2'd0);
                do_slot(2'd0);
            end
        end
        do_slot(2'd3);
        do_slot(2'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 64'(sp_en), 64'd0);
        chk("R1", 64'(sp_tag), 64'd0);
        chk("R1", 64'(sp_rx_dout), 64'd0);
        chk("R1", 64'(frm_tx_valid), 64'd0);
        chk("R1", 64'(frm_tx_bit), 64'd0);
        chk("R1", 64'(z_rx_word), 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < 5; v++) run_frame(v);

        // R11 with R2: partial frame, restart, untick OH cycle, then ordinal 0 again
        @(negedge clk);
        cfg_hw_ctl = 1'b0; cfg_frac_t1 = 1'b0; cfg_z_port = 1'b1;
        cfg_oh_predef = 42'h1;
        do_sof();
        repeat (3) do_slot(2'd1);
        do_sof();
        @(negedge clk);
        slot_kind = 2'd1;  // R2: no tick, must not count or drive
        @(posedge clk);
        @(negedge clk);
        slot_kind = 2'd0;
        chk("R2", 64'(sp_en), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2", 64'(frm_tx_valid), 64'd0);
        r11_mode = 1'b1;
        do_slot(2'd1);     // ordinal 0: predefined gap
        do_slot(2'd1);     // ordinal 1: on the port
        r11_mode = 1'b0;

        // R1: reset during operation clears the received word
        chk("R8", 64'(z_rx_word != 48'd0), 64'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", 64'(z_rx_word), 64'd0);
        chk("R1", 64'(sp_en), 64'd0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule